// File: doc/BRIEF.md
# Bus Hold Request Handshake Controller

This block decides who drives an external memory bus: the local memory controller or an outside requester. The requester pulls an active-low request line low to ask for the bus. The block first stops new local transfers from starting and waits until every transfer already running has finished. It then turns off the local bus drivers so that the bus floats. Only after that does it grant the bus by pulling an active-low acknowledge line low. A configuration input can hold back the grant for as long as it stays set.

When the requester raises its request line again, the block turns the local bus drivers back on. After that it raises the acknowledge line, and finally it lets local transfers run again. If the request is withdrawn before the grant, the block goes straight back to local ownership and never grants. The request line is resynchronised to the interface clock. Every delay is a fixed number of clock edges, which makes the grant and release edges predictable.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, holda_n_o is 1, bus_oe_o is 1 (local drivers on) and xfer_stall_o is 0.
- R2: bus_oe_o never falls on a clock edge at which xfer_busy_i is 1. A request that arrives while a transfer is in progress floats the bus on the first qualifying edge at which xfer_busy_i is 0.
- R3: While hold_block_i is 1, bus_oe_o stays 1 and holda_n_o stays 1, whatever hold_n_i does. The grant follows on the first qualifying edge after hold_block_i returns to 0.
- R4: With the default two-stage synchroniser and no transfer in progress, bus_oe_o falls on the 4th rising edge after hold_n_i goes low. This is never sooner than 2 edges after the request. holda_n_o falls exactly 1 edge after bus_oe_o falls.
- R5: After hold_n_i rises during a grant, bus_oe_o returns to 1 on the 3rd edge. This is the synchroniser depth plus one, kept within 2 to 7. holda_n_o returns to 1 exactly 2 edges after bus_oe_o returns.
- R6: xfer_stall_o goes to 1 on the first edge after the synchronised request is seen (the 3rd edge at default). It stays 1 while the request is pending or granted, and falls on the same edge at which holda_n_o returns to 1.
- R7: If hold_n_i rises before the grant, the block goes back to local ownership without ever lowering holda_n_o or bus_oe_o. xfer_stall_o falls on the 3rd edge after the rise.
- R8: With hold_n_i at 1, xfer_busy_i and hold_block_i have no effect: all three outputs keep their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_n_i | input | 1 | External bus request, active low, asynchronous |
| xfer_busy_i | input | 1 | A memory transfer is in progress |
| hold_block_i | input | 1 | Configuration bit that withholds the grant while 1 |
| holda_n_o | output | 1 | Bus grant acknowledge, active low |
| bus_oe_o | output | 1 | Output enable for all local bus drivers (1 = driven) |
| xfer_stall_o | output | 1 | Stops new transfers from starting |

## Verification
The assertions check the ordering rules on every cycle:
- the drivers never switch off on an edge where a transfer is busy or the grant is blocked;
- the acknowledge falls only one edge after the drivers switch off;
- the acknowledge rises only two edges after they switch back on;
- the stall covers every cycle in which the bus is floated or granted.

The exact edge counts measured from the request line depend on the synchroniser latency, so only the bench's scenarios can show them. The same holds for withdrawing a request before the grant, for blocking that lasts past the busy period, and for inputs being ignored while idle.

// File: rtl/bhold_pkg.sv
package bhold_pkg;

  // Ownership sequence of the external bus
  typedef enum logic [2:0] {
    ST_LOCAL  = 3'd0,  // local controller drives the bus
    ST_DRAIN  = 3'd1,  // request seen, waiting for transfers / block bit
    ST_FLOAT  = 3'd2,  // drivers off, grant not yet given
    ST_GRANT  = 3'd3,  // external requester owns the bus
    ST_RETAKE = 3'd4   // drivers back on, grant still held
  } own_state_e;

endpackage

// File: rtl/bhold_sync.sv
module bhold_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/bhold_lag_cnt.sv
module bhold_lag_cnt #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             done_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/bhold_fsm.sv
module bhold_fsm
  import bhold_pkg::*;
#(
  parameter int LAG_W       = 2,
  parameter int GRANT_LAG   = 1,
  parameter int RELEASE_LAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             busy_i,
  input  logic             block_i,
  input  logic             lag_done_i,
  output logic             lag_load_o,
  output logic [LAG_W-1:0] lag_val_o,
  output logic             oe_o,
  output logic             ack_n_o,
  output logic             stall_o
);

  localparam logic [LAG_W-1:0] GRANT_LOAD   = LAG_W'(GRANT_LAG - 1);
  localparam logic [LAG_W-1:0] RELEASE_LOAD = LAG_W'(RELEASE_LAG - 1);

  own_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    lag_load_o = 1'b0;
    lag_val_o  = GRANT_LOAD;
    unique case (state_q)
      ST_LOCAL: begin
        if (req_i) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!req_i) begin
          state_d = ST_LOCAL;
        end else if (!busy_i && !block_i) begin
          state_d    = ST_FLOAT;
          lag_load_o = 1'b1;
          lag_val_o  = GRANT_LOAD;
        end
      end
      ST_FLOAT: begin
        if (!req_i)          state_d = ST_LOCAL;
        else if (lag_done_i) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (!req_i) begin
          state_d    = ST_RETAKE;
          lag_load_o = 1'b1;
          lag_val_o  = RELEASE_LOAD;
        end
      end
      ST_RETAKE: begin
        if (lag_done_i) state_d = ST_LOCAL;
      end
      default: state_d = ST_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCAL;
    else        state_q <= state_d;
  end

  always_comb begin
    oe_o    = (state_q == ST_LOCAL) || (state_q == ST_DRAIN) || (state_q == ST_RETAKE);
    ack_n_o = !((state_q == ST_GRANT) || (state_q == ST_RETAKE));
    stall_o = (state_q != ST_LOCAL);
  end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int SYNC_STAGES = 2,  // 1..6: release drive delay is SYNC_STAGES+1 edges
  parameter int GRANT_LAG   = 1,  // edges from drivers off to grant
  parameter int RELEASE_LAG = 2   // edges from drivers on to grant removal
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_n_i,
  input  logic xfer_busy_i,
  input  logic hold_block_i,
  output logic holda_n_o,
  output logic bus_oe_o,
  output logic xfer_stall_o
);

  localparam int LAG_MAX = (GRANT_LAG > RELEASE_LAG) ? GRANT_LAG : RELEASE_LAG;
  localparam int LAG_W   = $clog2(LAG_MAX) + 1;

  logic             hold_n_s;
  logic             req;
  logic             lag_load;
  logic [LAG_W-1:0] lag_val;
  logic             lag_done;

  bhold_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hold_n_i),
    .q_o   (hold_n_s)
  );

  assign req = !hold_n_s;

  bhold_lag_cnt #(
    .WIDTH (LAG_W)
  ) u_lag (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (lag_load),
    .load_val_i (lag_val),
    .done_o     (lag_done)
  );

  bhold_fsm #(
    .LAG_W       (LAG_W),
    .GRANT_LAG   (GRANT_LAG),
    .RELEASE_LAG (RELEASE_LAG)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .busy_i     (xfer_busy_i),
    .block_i    (hold_block_i),
    .lag_done_i (lag_done),
    .lag_load_o (lag_load),
    .lag_val_o  (lag_val),
    .oe_o       (bus_oe_o),
    .ack_n_o    (holda_n_o),
    .stall_o    (xfer_stall_o)
  );

endmodule

// File: rtl/bhold_chk.sv
module bhold_chk (
  input logic clk,
  input logic rst_n,
  input logic xfer_busy_i,
  input logic hold_block_i,
  input logic holda_n_o,
  input logic bus_oe_o,
  input logic xfer_stall_o
);

  // R2
  float_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_o) |-> $past(!xfer_busy_i));

  // R3
  float_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe_o) |-> $past(!hold_block_i));

  // R4
  grant_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n_o) |-> (!bus_oe_o && $past(!bus_oe_o) && $past(bus_oe_o, 2)));

  // R5
  ungrant_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda_n_o) |-> (bus_oe_o && $past(bus_oe_o) && $past(bus_oe_o, 2) && !$past(bus_oe_o, 3)));

  // R6
  stall_while_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n_o |-> xfer_stall_o);

  // R6
  stall_while_floated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> xfer_stall_o);

endmodule

bind bus_hold_arbiter bhold_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_busy_i  (xfer_busy_i),
  .hold_block_i (hold_block_i),
  .holda_n_o    (holda_n_o),
  .bus_oe_o     (bus_oe_o),
  .xfer_stall_o (xfer_stall_o)
);

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 5;
  // fields: busy edges, block edges, hold edges after grant, expected oe-drop edge, expected grant edge
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 1, 4,  5},
    '{6, 0, 1, 7,  8},
    '{0, 9, 2, 10, 11},
    '{5, 8, 1, 9,  10},
    '{2, 0, 3, 4,  5}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic hold_n, busy, blk;
  logic holda_n, oe, stall;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_n_i     (hold_n),
    .xfer_busy_i  (busy),
    .hold_block_i (blk),
    .holda_n_o    (holda_n),
    .bus_oe_o     (oe),
    .xfer_stall_o (stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " holda_n"}, int'(holda_n), 1);
    chk({req, " oe"},      int'(oe),      1);
    chk({req, " stall"},   int'(stall),   0);
  endtask

  task automatic release_seq(input string tag);
    int oe_t = 0, ga_t = 0, st_t = 0;
    hold_n = 1'b1;
    for (int t = 1; t <= 8; t++) begin
      @(posedge clk); @(negedge clk);
      if (oe && oe_t == 0)      oe_t = t;
      if (holda_n && ga_t == 0) ga_t = t;
      if (!stall && st_t == 0)  st_t = t;
    end
    chk({tag, " R5 drive back edge"},    oe_t, 3);
    chk({tag, " R5 grant removal edge"}, ga_t, 5);
    chk({tag, " R6 stall drop edge"},    st_t, 5);
  endtask

  task automatic run_vec(input int b, input int k, input int h, input int eo, input int eg);
    int oe_t = 0, ga_t = 0, st_t = 0;
    @(negedge clk);
    hold_n = 1'b0; busy = (b > 0); blk = (k > 0);
    for (int t = 1; t <= 30; t++) begin
      @(posedge clk); @(negedge clk);
      if (!oe && oe_t == 0)      oe_t = t;
      if (!holda_n && ga_t == 0) ga_t = t;
      if (stall && st_t == 0)    st_t = t;
      busy = (t < b);
      blk  = (t < k);
      if (ga_t != 0 && t >= ga_t + h) break;
    end
    chk("R2/R3/R4 drivers off edge", oe_t, eo);
    chk("R4 grant edge", ga_t, eg);
    chk("R6 stall start edge", st_t, 3);
    release_seq("vec");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold_n = 1'b1; busy = 1'b0; blk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_idle("R1 after reset");

    // vector table
    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

    // R8: busy and block toggled with no request
    busy = 1'b1; blk = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(posedge clk); @(negedge clk);
      busy = ~busy;
    end
    chk_idle("R8 no request");
    busy = 1'b0; blk = 1'b0;

    // R7: request withdrawn before grant (block held)
    begin
      int lo_oe = 0, lo_ga = 0, st_t = 0;
      blk = 1'b1; hold_n = 1'b0;
      for (int t = 1; t <= 12; t++) begin
        @(posedge clk); @(negedge clk);
        if (!oe)      lo_oe = 1;
        if (!holda_n) lo_ga = 1;
        if (t == 5) hold_n = 1'b1;
        if (t > 3 && !stall && st_t == 0) st_t = t;
      end
      chk("R7 drivers never off", lo_oe, 0);
      chk("R7 grant never given", lo_ga, 0);
      chk("R7 stall drop edge after rise", st_t - 5, 3);
      blk = 1'b0;
    end

    // R1: reset while granted
    hold_n = 1'b0;
    repeat (6) begin @(posedge clk); @(negedge clk); end
    chk("R4 granted before reset", int'(holda_n), 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 async reset mid-grant");
    hold_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_idle("R1 after mid-grant reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule